// File: doc/BRIEF.md
# Bidirectional GPIO Port with Pulldown Control

This block is an 8-bit general-purpose I/O port that sits on a small microcontroller's register bus. It holds three registers: a data latch, a direction register and a pulldown-enable register. From these it drives per-pin output enables, output values and pulldown enables. A read of the data address returns a mix of values. Bits configured as outputs return the latch. Bits configured as inputs return the pad level after a two-stage synchroniser.

Each pad's raw input is also passed unchanged to other on-chip consumers, such as a capture timer or a comparator, whatever the pin's direction. A pin's pulldown can be on only when all three of these hold:
- the pin is an input;
- its pulldown bit is set;
- the global pulldown-disable input from the configuration option is low.

Software writes the data latch at any time. This lets it preload an output value before it turns the pin into an output.

Top module: `gpio_pd_port`

## Requirements
- R1: After reset every direction bit is 0, so `padOe` is 0x00. Every pulldown register bit is 1, so `padPdEn` is 0xFF while `pdGlobalDis` is low.
- R2: A register updates on the rising clock edge only when `busWrEn` is high and `busAddr` matches that register: data at 0x0001, direction at 0x0005, pulldown at 0x0011. A write with `busWrEn` low, or to any other address, changes no register.
- R3: On a read of 0x0001, each bit whose direction bit is 1 returns the data latch bit, whatever the pad level.
- R4: On a read of 0x0001, each bit whose direction bit is 0 returns the pad level through a two-flop synchroniser. A change on `padIn` shows after the second rising edge, not after the first.
- R5: The data latch accepts writes whatever the direction bits, and `padOut` always shows the latch. A value written while a pin is an input is driven as soon as the pin is switched to output.
- R6: `padPdEn` bit i is 0 whenever direction bit i is 1 (output).
- R7: `padPdEn` bit i is 0 when pulldown register bit i is 0, and all bits are 0 while `pdGlobalDis` is high.
- R8: The direction register reads back at 0x0005. A read of the write-only pulldown address 0x0011 returns 0x00 and changes no output.
- R9: `periphIn` equals `padIn` in the same cycle, for any direction setting.
- R10: `busRdData` is 0x00 when `busRdEn` is low, and when `busRdEn` is high at an unmapped address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 16 | Register address |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data (combinational) |
| pdGlobalDis | input | 1 | Global pulldown disable from configuration option |
| padIn | input | 8 | Raw pad input levels |
| padOut | output | 8 | Pad output values (data latch) |
| padOe | output | 8 | Pad output enables (direction) |
| padPdEn | output | 8 | Pad pulldown enables |
| periphIn | output | 8 | Raw pad levels forwarded to other modules |

## Verification
Suppose a direction bit is set wrongly. It shows at once on `padOe` and `padPdEn`, and on the next data read, which returns the latch where the pad level was expected. A pulldown register bit set wrongly is visible only on `padPdEn`, because the register cannot be read. So the bench checks that output after each pulldown write, and again after any read of 0x0011. A synchroniser with the wrong depth shows up as a one-cycle shift in when a pad change appears at 0x0001. The bench therefore samples after the first rising edge and again after the second.

// File: rtl/gpio_pd_pkg.sv
package gpio_pd_pkg;

  // Decoded bus actions passed from control to datapath
  typedef struct packed {
    logic dataWr;
    logic dirWr;
    logic pdWr;
    logic dataRd;
    logic dirRd;
  } portStrobe_t;

endpackage

// File: rtl/gpio_pd_sync.sv
module gpio_pd_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  localparam int WARM_W = $clog2(STAGES + 1);

  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stageQ[s] <= '0;
    end else begin
      stageQ[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) stageQ[s] <= stageQ[s-1];
    end
  end

  assign syncOut = stageQ[STAGES-1];

  // Cycles since reset, saturating, so the latency check never looks before reset
  logic [WARM_W-1:0] warmCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) warmCnt <= '0;
    else if (warmCnt != WARM_W'(STAGES)) warmCnt <= warmCnt + 1'b1;
  end

  generate
    if (STAGES == 2) begin : g_lat2
      AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
        (warmCnt == WARM_W'(STAGES)) |-> (syncOut == $past(asyncIn, 2))); // R4
    end
  endgenerate

endmodule

// File: rtl/gpio_pd_ctrl.sv
module gpio_pd_ctrl
  import gpio_pd_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'h0001,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 16'h0005,
  parameter logic [ADDR_W-1:0] PD_ADDR   = 16'h0011
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output portStrobe_t       strobe
);

  logic hitData, hitDir, hitPd;

  always_comb begin
    hitData = (busAddr == DATA_ADDR);
    hitDir  = (busAddr == DIR_ADDR);
    hitPd   = (busAddr == PD_ADDR);

    strobe.dataWr = busWrEn && hitData;
    strobe.dirWr  = busWrEn && hitDir;
    strobe.pdWr   = busWrEn && hitPd;
    // Pulldown register is write-only: no read select exists for it
    strobe.dataRd = busRdEn && hitData;
    strobe.dirRd  = busRdEn && hitDir;
  end

  always_comb begin
    AST_ONE_WRITE: assert ($onehot0({strobe.dataWr, strobe.dirWr, strobe.pdWr})); // R2
  end

endmodule

// File: rtl/gpio_pd_dpath.sv
module gpio_pd_dpath
  import gpio_pd_pkg::*;
#(
  parameter int               WIDTH    = 8,
  parameter logic [WIDTH-1:0] PD_RESET = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  portStrobe_t      strobe,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] syncIn,
  input  logic             pdGlobalDis,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] padPdEn
);

  logic [WIDTH-1:0] dataLatch;
  logic [WIDTH-1:0] dirReg;
  logic [WIDTH-1:0] pdReg;

  // Data latch is not reset: it is always writable and is preloaded by software
  always_ff @(posedge clk) begin
    if (strobe.dataWr) dataLatch <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg <= '0;
      pdReg  <= PD_RESET;
    end else begin
      if (strobe.dirWr) dirReg <= wrData;
      if (strobe.pdWr)  pdReg  <= wrData;
    end
  end

  // Per-pin pad control and read-back selection
  logic [WIDTH-1:0] pinView;
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      assign padPdEn[i] = pdReg[i] & ~dirReg[i] & ~pdGlobalDis;
      assign pinView[i] = dirReg[i] ? dataLatch[i] : syncIn[i];
    end
  endgenerate

  assign padOut = dataLatch;
  assign padOe  = dirReg;

  always_comb begin
    if (strobe.dataRd)     rdData = pinView;
    else if (strobe.dirRd) rdData = dirReg;
    else                   rdData = '0;
  end

  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.dirWr |=> $stable(dirReg)); // R2
  AST_PD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.pdWr |=> $stable(padPdEn) || !$stable(dirReg) || !$stable(pdGlobalDis)); // R8
  AST_DIR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dirWr |=> (padOe == $past(wrData))); // R2

  always_comb begin
    AST_PD_OFF_OUTPUT: assert ((padPdEn & padOe) == '0); // R6
    AST_PD_GLOBAL_OFF: assert (!pdGlobalDis || (padPdEn == '0)); // R7
  end

endmodule

// File: rtl/gpio_pd_port.sv
module gpio_pd_port
  import gpio_pd_pkg::*;
#(
  parameter int                WIDTH     = 8,
  parameter int                ADDR_W    = 16,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'h0001,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 16'h0005,
  parameter logic [ADDR_W-1:0] PD_ADDR   = 16'h0011,
  parameter logic [WIDTH-1:0]  PD_RESET  = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [WIDTH-1:0]  busWrData,
  output logic [WIDTH-1:0]  busRdData,
  input  logic              pdGlobalDis,
  input  logic [WIDTH-1:0]  padIn,
  output logic [WIDTH-1:0]  padOut,
  output logic [WIDTH-1:0]  padOe,
  output logic [WIDTH-1:0]  padPdEn,
  output logic [WIDTH-1:0]  periphIn
);

  portStrobe_t      strobe;
  logic [WIDTH-1:0] padSync;

  gpio_pd_ctrl #(
    .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR), .PD_ADDR(PD_ADDR)
  ) u_ctrl (
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr), .strobe(strobe)
  );

  gpio_pd_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(padIn), .syncOut(padSync)
  );

  gpio_pd_dpath #(.WIDTH(WIDTH), .PD_RESET(PD_RESET)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(busWrData), .syncIn(padSync),
    .pdGlobalDis(pdGlobalDis), .rdData(busRdData), .padOut(padOut), .padOe(padOe),
    .padPdEn(padPdEn)
  );

  // Raw pad level goes to other modules regardless of direction
  assign periphIn = padIn;

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |-> (busRdData == '0)); // R10

endmodule

// File: tb/sim_gpio_pd_port.sv
module sim_gpio_pd_port;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic        pdGlobalDis = 1'b0;
  logic [7:0]  padIn = '0;
  logic [7:0]  padOut, padOe, padPdEn, periphIn;

  int checkCount = 0;
  int failCount = 0;

  always #4 clk = ~clk;  // 125 MHz

  gpio_pd_port u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .busRdData(busRdData), .pdGlobalDis(pdGlobalDis),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .padPdEn(padPdEn), .periphIn(periphIn)
  );

  localparam logic [15:0] A_DATA = 16'h0001;
  localparam logic [15:0] A_DIR  = 16'h0005;
  localparam logic [15:0] A_PD   = 16'h0011;

  // Stimulus vectors {direction, latch, pad}
  localparam logic [23:0] VEC [6] = '{
    24'h00_5A_C3, 24'hFF_5A_C3, 24'h0F_A5_3C,
    24'hF0_A5_3C, 24'h81_00_FF, 24'h7E_FF_00
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    busRdEn = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    failCount++;
    checkCount++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 oe", padOe, 8'h00);
    check("R1 pd", padPdEn, 8'hFF);
    busRead(A_DIR, rd); check("R1 dir read", rd, 8'h00);

    // Vector table: R3/R4 read-back mix
    foreach (VEC[k]) begin
      logic [7:0] vDir, vDat, vPad;
      {vDir, vDat, vPad} = VEC[k];
      busWrite(A_DIR, vDir);
      busWrite(A_DATA, vDat);
      padIn = vPad;
      settle();
      busRead(A_DATA, rd);
      check("R3_R4 mixed read", rd, (vDat & vDir) | (vPad & ~vDir));
      check("R5 padOut", padOut, vDat);
      check("R6 pd vs dir", padPdEn, 8'hFF & ~vDir);
      check("R9 periph", periphIn, vPad);
    end

    // R2: write with strobe low, and to unmapped address
    busWrite(A_DIR, 8'h00);
    @(negedge clk); busAddr = A_DIR; busWrData = 8'hFF; busWrEn = 1'b0;
    @(negedge clk);
    busRead(A_DIR, rd); check("R2 no strobe", rd, 8'h00);
    busWrite(16'h0004, 8'hFF);
    busWrite(16'h0101, 8'hFF);
    busRead(A_DIR, rd); check("R2 unmapped write", rd, 8'h00);
    check("R2 oe unchanged", padOe, 8'h00);

    // R4 latency: two edges
    padIn = 8'h00; settle();
    @(negedge clk); padIn = 8'hA5;
    @(negedge clk);
    busAddr = A_DATA; busRdEn = 1'b1; #1 rd = busRdData; busRdEn = 1'b0;
    check("R4 after one edge", rd, 8'h00);
    @(negedge clk);
    busAddr = A_DATA; busRdEn = 1'b1; #1 rd = busRdData; busRdEn = 1'b0;
    check("R4 after two edges", rd, 8'hA5);

    // R5 preload while input
    padIn = 8'h00;
    busWrite(A_DATA, 8'h3C);
    settle();
    check("R5 latch while input", padOut, 8'h3C);
    busRead(A_DATA, rd); check("R5 input read shows pad", rd, 8'h00);
    busWrite(A_DIR, 8'hFF);
    busRead(A_DATA, rd); check("R5 preloaded drive", rd, 8'h3C);
    check("R5 oe", padOe, 8'hFF);
    check("R9 periph with outputs", periphIn, 8'h00);
    padIn = 8'hC3; settle();
    busRead(A_DATA, rd); check("R3 latch not pad", rd, 8'h3C);

    // R6/R7 pulldown gating
    busWrite(A_PD, 8'hFF);
    busWrite(A_DIR, 8'h0F);
    check("R6 outputs pd off", padPdEn, 8'hF0);
    busWrite(A_PD, 8'h55);
    check("R7 pd bits cleared", padPdEn, 8'h50);
    @(negedge clk); pdGlobalDis = 1'b1; #1;
    check("R7 global disable", padPdEn, 8'h00);
    @(negedge clk); pdGlobalDis = 1'b0; #1;
    check("R7 global release", padPdEn, 8'h50);

    // R8 pulldown read is 0 and harmless
    busRead(A_PD, rd); check("R8 pd read zero", rd, 8'h00);
    @(negedge clk);
    check("R8 pd unchanged", padPdEn, 8'h50);
    busRead(A_DIR, rd); check("R8 dir readback", rd, 8'h0F);

    // R10 idle and unmapped reads
    busRead(16'h0002, rd); check("R10 unmapped read", rd, 8'h00);
    @(negedge clk); busAddr = A_DIR; busRdEn = 1'b0; #1;
    check("R10 rd strobe low", busRdData, 8'h00);

    // R1 reset again restores defaults
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check("R1 oe after reset", padOe, 8'h00);
    check("R1 pd after reset", padPdEn, 8'hFF);

    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule